// File: doc/BRIEF.md
# Serially Loaded ROM Bank Controller

This block watches a CPU write bus and remaps two address streams into banked ROM space. Any CPU write in the upper half of the 64 KiB space, 0x8000 to 0xFFFF, feeds one data bit into a 5-bit serial shift register. The fifth write moves the collected value into one of four configuration registers. CPU address bits 14:13 of that fifth write choose the register.

The registers hold four things: the nametable mirroring code, the program banking layout, the character banking layout and the bank numbers. Three outputs are computed combinationally from these registers and the live buses:

- a program ROM address for the current CPU address;
- a character ROM address for the current picture-bus address;
- a 2-bit mirroring code.

The ROM sizes are parameters given as address widths. `PRG_AW` ranges over 15..19 and `CHR_AW` over 13..17. A program width of 19 (512 KiB) turns on large-ROM handling.

Top module: `sbank_ctrl`

## Requirements
- R1: A CPU write with address bit 15 clear leaves every banking register, the shift register and the write count unchanged.
- R2: An accepted serial write with data bit 7 set clears the shift register and the write count, and forces control bits 3 and 2 to 1. Control bits 4, 1 and 0 keep their values.
- R3: Any other accepted serial write shifts the 5-bit register right and inserts data bit 0 at bit 4. On the fifth such write, CPU address bits 14:13 pick the destination: 0 for control, 1 for character bank A, 2 for character bank B, 3 for the program bank (low 4 bits only). The shift register and count then clear.
- R4: A serial write in the clock cycle right after an accepted serial write is discarded.
- R5: `mirror` equals control bits 1:0, coded as follows: 0 is single-screen low, 1 is single-screen high, 2 is vertical, 3 is horizontal.
- R6: With control bit 4 set, picture addresses 0x0000-0x0FFF map through 4 KiB bank A and 0x1000-0x1FFF map through 4 KiB bank B. The mapped address is bank*4096 plus the low 12 address bits.
- R7: With control bit 4 clear, one 8 KiB character bank, bank A shifted right by one, maps all 13 picture address bits.
- R8: With control bit 3 clear, program ROM switches as one 32 KiB bank numbered by program bank bits 3:1. The low bit is ignored.
- R9: With control bits 3:2 equal to 2, CPU addresses with bit 14 clear map to 16 KiB bank 0, and addresses with bit 14 set map to the program bank.
- R10: With control bits 3:2 equal to 3, CPU addresses with bit 14 clear map to the program bank, and addresses with bit 14 set map to the last 16 KiB bank inside the low 256 KiB. After reset, control is 0x0C and mirroring is 0.
- R11: For a 512 KiB program ROM, the character bank registers keep only 4 bits. Bit 4 of a value loaded into bank A latches an outer select, which adds 256 KiB to every program address.
- R12: Character addresses are reduced modulo the character ROM size, so bank numbers past its end wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr | input | 16 | CPU address, used for writes and for program mapping |
| cpu_wdata | input | 8 | CPU write data |
| ppu_addr | input | 13 | Picture-bus pattern address |
| prg_addr | output | PRG_AW | Mapped program ROM byte address |
| chr_addr | output | CHR_AW | Mapped character ROM byte address |
| mirror | output | 2 | Nametable mirroring code |

## Verification
The assertions assume that `cpu_we` is a clean one-cycle strobe per CPU write. They also assume that the CPU address is stable while the strobe is high, so a write and the address it decodes belong to the same cycle. The bench drives every input on the falling edge and holds it for a full cycle. It releases the strobe between ordinary writes, except where it deliberately issues back-to-back pairs. Reset-bit writes and writes below 0x8000 are mixed into the random stream at a controlled rate, so five-write loads still complete often.

// File: rtl/sbank_ctrl.sv
module sbank_ctrl #(
  parameter int PRG_AW = 19,
  parameter int CHR_AW = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic [12:0]       ppu_addr,
  output logic [PRG_AW-1:0] prg_addr,
  output logic [CHR_AW-1:0] chr_addr,
  output logic [1:0]        mirror
);
  localparam bit BIG = (PRG_AW > 18);

  logic [4:0] sh, ctrl, chr_a, chr_b;
  logic [3:0] prg;
  logic [2:0] cnt;
  logic       outer, last;

  wire       take = cpu_we & cpu_addr[15] & ~last;
  wire [4:0] nxt  = {cpu_wdata[0], sh[4:1]};
  wire [4:0] cval = BIG ? {1'b0, nxt[3:0]} : nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh <= '0; cnt <= '0; ctrl <= 5'h0C;
      chr_a <= '0; chr_b <= '0; prg <= '0;
      outer <= 1'b0; last <= 1'b0;
    end else begin
      last <= take;
      if (take) begin
        if (cpu_wdata[7]) begin
          sh <= '0;
          cnt <= '0;
          ctrl <= ctrl | 5'h0C;
        end else if (cnt == 3'd4) begin
          sh <= '0;
          cnt <= '0;
          case (cpu_addr[14:13])
            2'd0: ctrl <= nxt;
            2'd1: begin
              chr_a <= cval;
              if (BIG) outer <= nxt[4];
            end
            2'd2: chr_b <= cval;
            default: prg <= nxt[3:0];
          endcase
        end else begin
          sh <= nxt;
          cnt <= cnt + 3'd1;
        end
      end
    end
  end

  logic [3:0] bank16;
  always_comb begin
    if (!ctrl[3])      bank16 = {prg[3:1], cpu_addr[14]};
    else if (!ctrl[2]) bank16 = cpu_addr[14] ? prg : 4'h0;
    else               bank16 = cpu_addr[14] ? 4'hF : prg;
  end

  wire [17:0] inner = {bank16, cpu_addr[13:0]};

  generate
    if (BIG) begin : g_big
      assign prg_addr = {outer, inner};
    end else begin : g_small
      assign prg_addr = inner[PRG_AW-1:0];
    end
  endgenerate

  wire [4:0]  cbank = ctrl[4] ? (ppu_addr[12] ? chr_b : chr_a)
                              : {chr_a[4:1], ppu_addr[12]};
  wire [16:0] cfull = {cbank, ppu_addr[11:0]};

  assign chr_addr = cfull[CHR_AW-1:0];
  assign mirror   = ctrl[1:0];
endmodule

// File: rtl/sbank_ctrl_chk.sv
module sbank_ctrl_chk #(
  parameter int PRG_AW = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_we,
  input logic [15:0]       cpu_addr,
  input logic [7:0]        cpu_wdata,
  input logic [PRG_AW-1:0] prg_addr,
  input logic [4:0]        sh,
  input logic [4:0]        ctrl,
  input logic [4:0]        chr_a,
  input logic [4:0]        chr_b,
  input logic [3:0]        prg,
  input logic [2:0]        cnt,
  input logic              last
);
  localparam int HI = (PRG_AW > 18) ? 17 : PRG_AW - 1;

  // R1
  low_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_we && !cpu_addr[15] |=> $stable({sh, cnt, ctrl, chr_a, chr_b, prg}));

  // R2
  reset_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_we && cpu_addr[15] && !last && cpu_wdata[7]
      |=> ctrl[3:2] == 2'b11 && cnt == 3'd0 && sh == 5'd0);

  // R3
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 3'd4);

  // R4
  back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last && cpu_we && cpu_addr[15] |=> $stable({sh, cnt, ctrl, chr_a, chr_b, prg}));

  // R8
  prg32_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[3] |-> prg_addr[14:0] == cpu_addr[14:0]);

  // R10
  fixed_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[3:2] == 2'b11 && cpu_addr[14]
      |-> prg_addr[13:0] == cpu_addr[13:0] && (&prg_addr[HI:14]));
endmodule

bind sbank_ctrl sbank_ctrl_chk #(.PRG_AW(PRG_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
  .cpu_wdata(cpu_wdata), .prg_addr(prg_addr), .sh(sh), .ctrl(ctrl),
  .chr_a(chr_a), .chr_b(chr_b), .prg(prg), .cnt(cnt), .last(last)
);

// File: tb/sbank_ctrl_tb.sv
module sbank_ctrl_tb;
  localparam int PRG_AW = 19;
  localparam int CHR_AW = 15;
  localparam bit BIG = (PRG_AW > 18);

  logic clk = 0, rst_n = 0, cpu_we = 0;
  logic [15:0] cpu_addr = 0;
  logic [7:0]  cpu_wdata = 0;
  logic [12:0] ppu_addr = 0;
  logic [PRG_AW-1:0] prg_addr;
  logic [CHR_AW-1:0] chr_addr;
  logic [1:0] mirror;
  int compared = 0, mismatched = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sbank_ctrl #(.PRG_AW(PRG_AW), .CHR_AW(CHR_AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .ppu_addr(ppu_addr), .prg_addr(prg_addr),
    .chr_addr(chr_addr), .mirror(mirror));

  logic [4:0] m_sh, m_ctrl, m_a, m_b;
  logic [3:0] m_prg;
  int m_cnt;
  bit m_outer, m_last;

  task automatic model_reset();
    m_sh = 0; m_ctrl = 5'h0C; m_a = 0; m_b = 0; m_prg = 0;
    m_cnt = 0; m_outer = 0; m_last = 0;
  endtask

  task automatic model_step(input bit we, input logic [15:0] a, input logic [7:0] d);
    logic [4:0] v;
    if (we && a[15] && !m_last) begin
      m_last = 1;
      if (d[7]) begin
        m_sh = 0; m_cnt = 0; m_ctrl = m_ctrl | 5'h0C;
      end else begin
        v = {d[0], m_sh[4:1]};
        m_cnt++;
        m_sh = v;
        if (m_cnt == 5) begin
          case (a[14:13])
            2'd0: m_ctrl = v;
            2'd1: begin m_a = BIG ? (v & 5'hF) : v; if (BIG) m_outer = v[4]; end
            2'd2: m_b = BIG ? (v & 5'hF) : v;
            default: m_prg = v[3:0];
          endcase
          m_sh = 0; m_cnt = 0;
        end
      end
    end else m_last = 0;
  endtask

  function automatic int exp_prg(input logic [15:0] a);
    int psz = 1 << PRG_AW;
    int off = int'(a[13:0]);
    int r;
    if (!m_ctrl[3]) r = ((int'(m_prg) >> 1) * 32768 + int'(a[14:0])) % psz;
    else if (!m_ctrl[2]) r = a[14] ? (int'(m_prg) * 16384 + off) % psz : off;
    else if (a[14]) begin
      r = psz - 16384;
      if (r > 262144) r -= 262144;
      r += off;
    end else r = (int'(m_prg) * 16384 + off) % psz;
    if (m_outer && BIG) r += 262144;
    return r;
  endfunction

  function automatic int exp_chr(input logic [12:0] p);
    int csz = 1 << CHR_AW;
    if (m_ctrl[4]) return (int'(p[12] ? m_b : m_a) * 4096 + int'(p[11:0])) % csz;
    return ((int'(m_a) >> 1) * 8192 + int'(p)) % csz;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit we, input logic [15:0] a, input logic [7:0] d);
    cpu_we = we; cpu_addr = a; cpu_wdata = d;
    model_step(we, a, d);
    @(posedge clk); @(negedge clk);
    cpu_we = 0;
  endtask

  task automatic load(input logic [15:0] a, input logic [4:0] v);
    for (int i = 0; i < 5; i++) begin
      cyc(1, a, {1'b0, 6'($urandom), v[i]});
      cyc(0, 16'h0000, 8'h00);
    end
  endtask

  task automatic probe(input logic [15:0] a, input logic [12:0] p);
    string pt, ct;
    cpu_addr = a; ppu_addr = p;
    #1;
    // R8 R9 R10 R11 program mapping; R6 R7 R12 character mapping; R5 mirror
    pt = !m_ctrl[3] ? "R8" : (!m_ctrl[2] ? "R9" : "R10");
    if (m_outer) pt = {pt, "/R11"};
    ct = m_ctrl[4] ? "R6/R12" : "R7/R12";
    chk(pt, int'(prg_addr), exp_prg(a));
    chk(ct, int'(chr_addr), exp_chr(p));
    chk("R5", int'(mirror), int'(m_ctrl[1:0]));
  endtask

  task automatic probes(input int n);
    for (int i = 0; i < n; i++) probe(16'($urandom) | 16'h8000, 13'($urandom));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 reset state: last bank fixed at 0xC000, mirror 0
    probe(16'hC000, 13'h0000);
    chk("R10", int'(mirror), 0);

    // R5 each mirroring code, R6 4K mode, R8 32K mode
    for (int m = 0; m < 4; m++) begin
      load(16'h8000, 5'(m));
      probe(16'hC123, 13'h0456);
    end
    load(16'h8000, 5'b10010);
    load(16'hA000, 5'd3);
    load(16'hC000, 5'd6);
    load(16'hE000, 5'd7);
    probes(4);
    // R12 character wrap: bank 12 beyond a 32 KiB ROM
    load(16'hA000, 5'd12);
    probe(16'h8000, 13'h0010);
    // R7 8K mode, R9 fixed first
    load(16'h8000, 5'b01001);
    probes(4);
    // R11 outer select from bank A bit 4, chr mask to 4 bits
    load(16'hA000, 5'b11101);
    probes(4);
    load(16'hC000, 5'b11111);
    probes(2);
    // R2 reset bit mid-load
    cyc(1, 16'hE000, 8'h01); cyc(0, 0, 0);
    cyc(1, 16'hE000, 8'h01); cyc(0, 0, 0);
    cyc(1, 16'h9000, 8'h80); cyc(0, 0, 0);
    load(16'hE000, 5'd9);
    probes(3);
    // R4 back-to-back writes: second of each pair dropped
    for (int i = 0; i < 10; i++) cyc(1, 16'hE000, 8'($urandom) & 8'h7F);
    cyc(0, 0, 0);
    probes(3);
    // R1 low writes
    for (int i = 0; i < 6; i++) begin
      cyc(1, 16'($urandom) & 16'h7FFF, 8'($urandom));
      cyc(0, 0, 0);
    end
    probes(3);

    // R3 random serial traffic
    for (int it = 0; it < 1500; it++) begin
      int op = $urandom_range(0, 9);
      logic [15:0] a = 16'($urandom) | 16'h8000;
      logic [7:0]  d = 8'($urandom) & 8'h7F;
      if (op == 0) d[7] = ($urandom_range(0, 3) == 0);
      if (op == 1) a[15] = 0;
      if (op == 2) begin cyc(1, a, d); cyc(1, 16'($urandom) | 16'h8000, 8'($urandom) & 8'h7F); end
      else if (op == 3) cyc(0, 0, 0);
      else cyc(1, a, d);
      cyc(0, 0, 0);
      if (it % 3 == 0) probes(1);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule